// File: doc/BRIEF.md
# Residue-Checked Two-Cycle Multiplier

This block multiplies two 32-bit operands that arrive with 16-bit residue vectors over the moduli 5, 7, 17 and 31. It writes the 64-bit product back as two 32-bit words on consecutive cycles, upper word first. Each word comes with its own residue vector. That vector is not obtained by encoding the word. It is derived from the product of the operand residues, minus the residue of the other word scaled by a constant. So a mismatch between the data path and the residue path stays visible.

Each of the two write-back cycles also captures a predicted residue for the word being written and an encoded residue of the other word. This fills four check registers: a predicted and an actual residue for the upper word, and the same pair for the lower word. A comparator watches the two pairs at all times. The comparison is masked in the two multiply cycles, because the registers are only half updated then. In every other cycle a mismatch clears the OK output, which stays low until reset.

The controller has three states: `ST_IDLE`, `ST_MUL_HI` and `ST_MUL_LO`. Its transitions are:
- `ST_IDLE` to `ST_MUL_HI` when `start` is high.
- `ST_IDLE` to `ST_IDLE` otherwise.
- `ST_MUL_HI` to `ST_MUL_LO` always.
- `ST_MUL_LO` to `ST_IDLE` always.

Top module: `rmul_core`

## Requirements
- R1: While reset is held and on the first cycle after it, `ok` is 1 and `wb_valid` is 0.
- R2: A `start` sampled in the idle state yields `wb_valid`=1 with `wb_hi`=1 on the next cycle. The cycle after that has `wb_valid`=1 with `wb_hi`=0, and the block is idle on the cycle after.
- R3: The word written with `wb_hi`=1 is bits 63..32 of `op_a*op_b` (unsigned), and the word written with `wb_hi`=0 is bits 31..0.
- R4: A residue vector holds the value mod 5 in bits 2..0, mod 7 in bits 5..3, mod 17 in bits 10..6 and mod 31 in bits 15..11. Operand and write-back vectors share this layout, and every write-back field is below its modulus.
- R5: When the operand residue vectors are correct, each written-back residue vector equals the true residue vector of the written word.
- R6: `start` is ignored in `ST_MUL_HI` and `ST_MUL_LO`: no extra write-back follows, and the operands are not replaced.
- R7: `ok` stays 1 during both multiply cycles unless it had already dropped before them.
- R8: If the operand residues do not match the operands, `ok` is 0 on the first cycle after the `wb_hi`=0 cycle. This covers a single flipped bit in an operand or in a residue field whose product residue changes.
- R9: Once `ok` has dropped, it stays 0 through later correct multiplications until reset.
- R10: Correct operands, including zero and all-ones, leave `ok` at 1 after the multiplication.
- R11: A `start` in the idle cycle that directly follows a `wb_hi`=0 cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication (sampled in idle only) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| res_a | input | 16 | Residue vector of `op_a` |
| res_b | input | 16 | Residue vector of `op_b` |
| wb_valid | output | 1 | A product word is being written back |
| wb_hi | output | 1 | 1 for the upper word, 0 for the lower word |
| wb_word | output | 32 | Product word written back |
| wb_res | output | 16 | Derived residue vector of `wb_word` |
| ok | output | 1 | Integrity flag, sticky low on a check mismatch |

## Verification
The bench runs small operands, a zero operand and all-ones operands. With these, a wrong half of the product, a wrong constant factor or a faulty chunk fold shows up in the word or residue comparisons. Three kinds of fault are injected: a flipped operand data bit with its residue kept, a flipped bit in the mod 5 field and a flipped bit in the mod 31 field. They show whether the check-register pairing and the two-cycle mask let `ok` fall exactly one cycle after the lower word. `start` held high across a whole multiplication, and a start issued right after the lower word, separate correct busy-ignoring from lost or duplicated operations.

// File: rtl/rmul_pkg.sv
package rmul_pkg;

    localparam int NUM_MOD = 4;
    localparam int RES_W   = 16;

    // moduli, fold chunk widths (2^chunk == 1 mod m), field widths and offsets
    localparam int unsigned MODS [NUM_MOD] = '{5, 7, 17, 31};
    localparam int unsigned FOLD [NUM_MOD] = '{4, 3, 8, 5};
    localparam int unsigned RWID [NUM_MOD] = '{3, 3, 5, 5};
    localparam int unsigned ROFF [NUM_MOD] = '{0, 3, 6, 11};

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MUL_HI = 2'd1,
        ST_MUL_LO = 2'd2
    } mul_state_e;

    function automatic int unsigned pow2_mod(input int unsigned e, input int unsigned m);
        int unsigned r;
        r = 1;
        for (int unsigned i = 0; i < e; i++) begin
            r = (r * 2) % m;
        end
        return r;
    endfunction

    function automatic int unsigned inv_mod(input int unsigned a, input int unsigned m);
        int unsigned found;
        found = 0;
        for (int unsigned x = 1; x < m; x++) begin
            if (found == 0 && ((a * x) % m) == 1) begin
                found = x;
            end
        end
        return found;
    endfunction

endpackage

// File: rtl/rmul_fold_enc.sv
module rmul_fold_enc #(
    parameter int unsigned MOD    = 5,
    parameter int unsigned CHUNK  = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned RW     = 3
) (
    input  logic [DATA_W-1:0] val,
    output logic [RW-1:0]     res
);
    localparam int unsigned NCH = (DATA_W + CHUNK - 1) / CHUNK;
    localparam int unsigned SW  = CHUNK + $clog2(NCH) + 1;

    logic [NCH*CHUNK-1:0] padded;
    logic [SW-1:0]        acc;

    assign padded = (NCH*CHUNK)'(val);

    // chunks of weight 2^(k*CHUNK) are all congruent to 1, so they just add up
    always_comb begin
        acc = '0;
        for (int i = 0; i < int'(NCH); i++) begin
            acc = acc + SW'(padded[i*CHUNK +: CHUNK]);
        end
    end

    assign res = RW'(acc % SW'(MOD));

endmodule

// File: rtl/rmul_res_lane.sv
module rmul_res_lane #(
    parameter int unsigned MOD    = 5,
    parameter int unsigned CHUNK  = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned RW     = 3,
    parameter int unsigned K_LO   = 1,
    parameter int unsigned K_INV  = 1
) (
    input  logic [RW-1:0]     ra,
    input  logic [RW-1:0]     rb,
    input  logic [DATA_W-1:0] lo_w,
    input  logic [DATA_W-1:0] hi_w,
    output logic [RW-1:0]     lo_mod,
    output logic [RW-1:0]     hi_mod,
    output logic [RW-1:0]     lo_res,
    output logic [RW-1:0]     hi_res
);
    localparam int unsigned XW = 2*RW + 4;

    logic [XW-1:0] pc;
    logic [XW-1:0] hk;
    logic [XW-1:0] lo_x;
    logic [XW-1:0] diff_x;
    logic [XW-1:0] hi_x;

    rmul_fold_enc #(.MOD(MOD), .CHUNK(CHUNK), .DATA_W(DATA_W), .RW(RW))
        u_enc_lo (.val(lo_w), .res(lo_mod));

    rmul_fold_enc #(.MOD(MOD), .CHUNK(CHUNK), .DATA_W(DATA_W), .RW(RW))
        u_enc_hi (.val(hi_w), .res(hi_mod));

    always_comb begin
        // residue of the full product from the operand residues
        pc     = (XW'(ra) * XW'(rb)) % XW'(MOD);
        // low word: pc - hi * 2^W
        hk     = (XW'(hi_mod) * XW'(K_LO)) % XW'(MOD);
        lo_x   = (pc + XW'(MOD) - hk) % XW'(MOD);
        // high word: (pc - lo) * 2^-W
        diff_x = (pc + XW'(MOD) - XW'(lo_mod)) % XW'(MOD);
        hi_x   = (diff_x * XW'(K_INV)) % XW'(MOD);
    end

    assign lo_res = RW'(lo_x);
    assign hi_res = RW'(hi_x);

endmodule

// File: rtl/rmul_ctrl.sv
module rmul_ctrl
    import rmul_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output mul_state_e state,
    output logic       load_ops,
    output logic       cap_hi,
    output logic       cap_lo,
    output logic       chk_mask
);
    mul_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:   nxt = start ? ST_MUL_HI : ST_IDLE;
            ST_MUL_HI: nxt = ST_MUL_LO;
            ST_MUL_LO: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load_ops = 1'b0;
        cap_hi   = 1'b0;
        cap_lo   = 1'b0;
        chk_mask = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load_ops = start;
            end
            ST_MUL_HI: begin
                cap_hi   = 1'b1;
                chk_mask = 1'b1;
            end
            ST_MUL_LO: begin
                cap_lo   = 1'b1;
                chk_mask = 1'b1;
            end
            default: begin
                load_ops = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rmul_core.sv
module rmul_core
    import rmul_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [RES_W-1:0]  res_a,
    input  logic [RES_W-1:0]  res_b,
    output logic              wb_valid,
    output logic              wb_hi,
    output logic [DATA_W-1:0] wb_word,
    output logic [RES_W-1:0]  wb_res,
    output logic              ok
);
    localparam int unsigned PROD_W = 2 * DATA_W;

    mul_state_e state;
    logic load_ops, cap_hi, cap_lo, chk_mask;

    logic [DATA_W-1:0] a_q, b_q;
    logic [RES_W-1:0]  ra_q, rb_q;
    logic [PROD_W-1:0] product;
    logic [DATA_W-1:0] hi_w, lo_w;

    logic [RES_W-1:0] lo_mod_v, hi_mod_v, lo_res_v, hi_res_v;

    // check registers: predicted and encoded residue of each half
    logic [RES_W-1:0] chk_hi_pred_q, chk_hi_act_q;
    logic [RES_W-1:0] chk_lo_pred_q, chk_lo_act_q;
    logic             match;
    logic             err_q;

    rmul_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .state    (state),
        .load_ops (load_ops),
        .cap_hi   (cap_hi),
        .cap_lo   (cap_lo),
        .chk_mask (chk_mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            ra_q <= '0;
            rb_q <= '0;
        end else if (load_ops) begin
            a_q  <= op_a;
            b_q  <= op_b;
            ra_q <= res_a;
            rb_q <= res_b;
        end
    end

    assign product = PROD_W'(a_q) * PROD_W'(b_q);
    assign hi_w    = product[PROD_W-1:DATA_W];
    assign lo_w    = product[DATA_W-1:0];

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_lane
        localparam int unsigned LM    = MODS[g];
        localparam int unsigned LW    = RWID[g];
        localparam int unsigned LO    = ROFF[g];
        localparam int unsigned K_LO  = pow2_mod(DATA_W, LM);
        localparam int unsigned K_INV = inv_mod(K_LO, LM);

        rmul_res_lane #(
            .MOD    (LM),
            .CHUNK  (FOLD[g]),
            .DATA_W (DATA_W),
            .RW     (LW),
            .K_LO   (K_LO),
            .K_INV  (K_INV)
        ) u_lane (
            .ra     (ra_q[LO +: LW]),
            .rb     (rb_q[LO +: LW]),
            .lo_w   (lo_w),
            .hi_w   (hi_w),
            .lo_mod (lo_mod_v[LO +: LW]),
            .hi_mod (hi_mod_v[LO +: LW]),
            .lo_res (lo_res_v[LO +: LW]),
            .hi_res (hi_res_v[LO +: LW])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_hi_pred_q <= '0;
            chk_lo_act_q  <= '0;
            chk_lo_pred_q <= '0;
            chk_hi_act_q  <= '0;
        end else begin
            if (cap_hi) begin
                chk_hi_pred_q <= hi_res_v;
                chk_lo_act_q  <= lo_mod_v;
            end
            if (cap_lo) begin
                chk_lo_pred_q <= lo_res_v;
                chk_hi_act_q  <= hi_mod_v;
            end
        end
    end

    assign match = (chk_hi_pred_q == chk_hi_act_q) && (chk_lo_pred_q == chk_lo_act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (!chk_mask && !match) begin
            err_q <= 1'b1;
        end
    end

    assign ok = !err_q && (chk_mask || match);

    always_comb begin
        wb_valid = 1'b0;
        wb_hi    = 1'b0;
        wb_word  = '0;
        wb_res   = '0;
        unique case (state)
            ST_MUL_HI: begin
                wb_valid = 1'b1;
                wb_hi    = 1'b1;
                wb_word  = hi_w;
                wb_res   = hi_res_v;
            end
            ST_MUL_LO: begin
                wb_valid = 1'b1;
                wb_word  = lo_w;
                wb_res   = lo_res_v;
            end
            default: begin
                wb_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rmul_core_chk.sv
module rmul_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        wb_valid,
    input logic        wb_hi,
    input logic [15:0] wb_res,
    input logic        ok,
    input logic        err_q
);
    // R2
    start_to_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wb_valid) |=> (wb_valid && wb_hi));

    // R2
    hi_to_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_hi) |=> (wb_valid && !wb_hi));

    // R6
    lo_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_hi) |=> !wb_valid);

    // R9
    ok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ok |=> !ok);

    // R7
    mask_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !err_q) |-> ok);

    // R4
    res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_res[2:0] < 3'd5 && wb_res[5:3] < 3'd7 &&
                      wb_res[10:6] < 5'd17 && wb_res[15:11] < 5'd31));
endmodule

bind rmul_core rmul_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .wb_valid (wb_valid),
    .wb_hi    (wb_hi),
    .wb_res   (wb_res),
    .ok       (ok),
    .err_q    (err_q)
);

// File: tb/test_rmul_core.sv
module test_rmul_core;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        hi;
        logic [31:0] word;
        logic [15:0] res;
        logic        chk;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [15:0] res_a = '0, res_b = '0;
    logic        wb_valid, wb_hi, ok;
    logic [31:0] wb_word;
    logic [15:0] wb_res;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rmul_core i_rmul_core (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .res_a(res_a), .res_b(res_b),
        .wb_valid(wb_valid), .wb_hi(wb_hi), .wb_word(wb_word),
        .wb_res(wb_res), .ok(ok)
    );

    // R4 layout: mod5 [2:0], mod7 [5:3], mod17 [10:6], mod31 [15:11]
    function automatic logic [15:0] enc(input logic [31:0] v);
        return {5'(v % 31), 5'(v % 17), 3'(v % 7), 3'(v % 5)};
    endfunction

    task automatic check(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // driver: pushes both expected words, pulses start, returns in the high-word cycle
    task automatic do_mul(input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] ra, input logic [15:0] rb, input bit chk);
        logic [63:0] p;
        p = 64'(a) * 64'(b);
        q.push_back('{hi: 1'b1, word: p[63:32], res: enc(p[63:32]), chk: chk});
        q.push_back('{hi: 1'b0, word: p[31:0],  res: enc(p[31:0]),  chk: chk});
        @(negedge clk);
        op_a = a; op_b = b; res_a = ra; res_b = rb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic good_mul(input logic [31:0] a, input logic [31:0] b);
        do_mul(a, b, enc(a), enc(b), 1'b1);
    endtask

    // monitor: pops and compares each write-back
    always @(negedge clk) begin
        if (rst_n && wb_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R6 unexpected write-back", 64'(wb_word), 64'(0));
            end else begin
                automatic exp_t e = q.pop_front();
                check(wb_hi == e.hi, "R2 word order", 64'(wb_hi), 64'(e.hi));
                check(wb_word == e.word, "R3 product word", 64'(wb_word), 64'(e.word));
                if (e.chk) begin
                    check(wb_res == e.res, "R5 derived residue", 64'(wb_res), 64'(e.res));
                end
            end
        end
    end

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(ok == 1'b1, "R1 ok in reset", 64'(ok), 64'(1));
        check(wb_valid == 1'b0, "R1 wb_valid in reset", 64'(wb_valid), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(ok == 1'b1, "R1 ok after reset", 64'(ok), 64'(1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ok == 1'b1, "R1 ok in reset", 64'(ok), 64'(1));
        check(wb_valid == 1'b0, "R1 wb_valid in reset", 64'(wb_valid), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R10 consistent operands incl. zero and all-ones
        good_mul(32'd3, 32'd5);
        @(negedge clk); @(negedge clk);
        check(ok == 1'b1, "R10 ok small", 64'(ok), 64'(1));
        good_mul(32'd0, 32'hDEADBEEF);
        @(negedge clk); @(negedge clk);
        check(ok == 1'b1, "R10 ok zero", 64'(ok), 64'(1));
        good_mul(32'hFFFFFFFF, 32'hFFFFFFFF);
        @(negedge clk); @(negedge clk);
        check(ok == 1'b1, "R10 ok all-ones", 64'(ok), 64'(1));

        // R11 back-to-back: next start in the idle cycle right after the low word
        good_mul(32'h12345678, 32'h9ABCDEF0);
        @(negedge clk);
        good_mul(32'h0F0F0F0F, 32'h00010003);
        check(wb_valid && wb_hi, "R11 back-to-back accepted", 64'(wb_valid), 64'(1));
        @(negedge clk); @(negedge clk);
        check(ok == 1'b1, "R11 ok after back-to-back", 64'(ok), 64'(1));

        // R6 start held through the whole operation with changed operands
        do_mul(32'd1234567, 32'd89, enc(32'd1234567), enc(32'd89), 1'b1);
        start = 1'b1; op_a = 32'hAAAA5555; op_b = 32'h13579BDF;
        res_a = enc(op_a); res_b = enc(op_b);
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        check(wb_valid == 1'b0, "R6 start ignored while busy", 64'(wb_valid), 64'(0));
        @(negedge clk);
        check(wb_valid == 1'b0, "R6 no second operation", 64'(wb_valid), 64'(0));
        check(ok == 1'b1, "R6 ok kept", 64'(ok), 64'(1));

        // R7 R8 R9 fault: flipped mod5 residue bit of op_a
        do_mul(32'd1000, 32'd7, enc(32'd1000) ^ 16'h0001, enc(32'd7), 1'b0);
        check(ok == 1'b1, "R7 ok masked in high cycle", 64'(ok), 64'(1));
        @(negedge clk);
        check(ok == 1'b1, "R7 ok masked in low cycle", 64'(ok), 64'(1));
        @(negedge clk);
        check(ok == 1'b0, "R8 residue flip detected", 64'(ok), 64'(0));
        @(negedge clk);
        check(ok == 1'b0, "R9 ok stays low", 64'(ok), 64'(0));
        good_mul(32'd77, 32'd99);
        @(negedge clk); @(negedge clk);
        check(ok == 1'b0, "R9 ok low after good op", 64'(ok), 64'(0));
        reset_dut();

        // R8 fault: flipped data bit of op_a, residue kept
        do_mul(32'd1000 ^ 32'd32, 32'd7, enc(32'd1000), enc(32'd7), 1'b0);
        @(negedge clk);
        check(ok == 1'b1, "R7 ok masked before detection", 64'(ok), 64'(1));
        @(negedge clk);
        check(ok == 1'b0, "R8 data flip detected", 64'(ok), 64'(0));
        reset_dut();

        // R8 fault: flipped bit 11 (mod31 field) of res_b
        do_mul(32'd1000, 32'd7, enc(32'd1000), enc(32'd7) ^ 16'h0800, 1'b0);
        @(negedge clk); @(negedge clk);
        check(ok == 1'b0, "R8 mod31 field flip detected", 64'(ok), 64'(0));
        reset_dut();

        good_mul(32'h80000001, 32'h7FFFFFFF);
        @(negedge clk); @(negedge clk);
        check(ok == 1'b1, "R10 ok after recovery", 64'(ok), 64'(1));
        check(q.size() == 0, "R2 all words written back", 64'(q.size()), 64'(0));

        done = 1'b1;
        report();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end

endmodule